// File: doc/BRIEF.md
# Display Mode and Power State Controller

This block sits behind the host command path of a colour display driver. It takes one-byte mode commands, each marked by a single-cycle strobe, and holds the operating state of the panel. That state covers sleep, booster enable, display on/off, normal or partial drive, all-pixels-on, all-pixels-off, inversion, idle colour reduction and the tearing output. Each stored flag keeps its own value. The block derives the enables that the drive stages act on from those flags and from a supply-ready level that arrives from the analog domain.

Sleep masks the booster and the display without changing their stored flags, so waking up brings back whatever the host last chose. The display is driven only once the booster is enabled and the supply reports ready. On a status-read command the block captures a 32-bit status word. It then shifts the word out on a serial line, one bit per shift strobe, after one leading dummy bit.

Top module: `dmc_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset the stored state is: asleep, booster flag 1, display flag 1, inversion 0, normal mode 1, partial 0, all-on 0, all-off 0, idle 0, tearing 0. All drive enables are 0, `stat_busy` is 0 and `cmd_err` is 0.
- R2: Opcode 10h puts the block to sleep and 11h wakes it. `booster_run` equals booster flag AND awake. Sleep leaves the stored booster and display flags unchanged.
- R3: Opcode 02h clears the booster flag and 03h sets it. Opcode 28h clears the display flag and 29h sets it. Each takes effect on the clock edge that samples the strobe.
- R4: `supply_rdy_async` passes through a two-flop synchronizer. `display_drive` equals awake AND display flag AND booster flag AND the synchronized ready, so a rising ready reaches `display_drive` on the second clock edge.
- R5: Opcode 12h sets partial and clears normal, all-on and all-off. Opcode 13h sets normal and clears partial, all-on and all-off. `partial_drive` equals `display_drive` AND partial.
- R6: Opcode 23h sets all-on and clears all-off. Opcode 22h sets all-off and clears all-on. `all_on_drive` and `all_off_drive` follow their flags gated by `display_drive`. `invert_drive` is 0 whenever all-on or all-off is set.
- R7: Opcodes 20h/21h clear/set inversion, 38h/39h clear/set idle, and 34h/35h clear/set tearing. `invert_drive` and `idle_drive` are gated by `display_drive`. `tear_en` follows the tearing flag directly.
- R8: Opcode 01h restores the R1 state in one cycle and ends any status read in progress.
- R9: Opcodes B0h to B9h and DEh to FFh change no state and raise `cmd_err` for exactly the following cycle. Any other opcode not listed in R2 to R11, including 00h and DDh, changes no mode flag and raises no error.
- R10: The status word holds the following fields. Bit 31 is booster flag AND synchronized ready. Bits 30:26 are `orient_cfg`, bits 25:23 are 0 and bits 22:20 are `pixfmt_cfg`. Bit 19 is idle, bit 18 partial, bit 17 awake and bit 16 normal. Bits 15 and 14 are 0. Bit 13 is inversion, bit 12 all-on, bit 11 all-off, bit 10 display flag and bit 9 tearing. Bits 8:0 are 0. Mode flags are sampled at the edge that accepts opcode 09h.
- R11: After opcode 09h, `stat_busy` is 1 and `stat_sdo` shows a dummy 0. Each `stat_shift` strobe advances one bit, bit 31 first. After the 33rd strobe `stat_busy` returns to 0 and `stat_sdo` is 0 while idle.
- R12: Any command strobe during a status read ends that read. Opcode 09h instead restarts it with a fresh snapshot. A command and a shift strobe in the same cycle let the command win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe qualifying `cmd_byte` |
| cmd_byte | input | 8 | Command opcode |
| supply_rdy_async | input | 1 | Supply-ready level from the analog domain, asynchronous |
| orient_cfg | input | 5 | Orientation settings reported in status bits 30:26 |
| pixfmt_cfg | input | 3 | Pixel format reported in status bits 22:20 |
| stat_shift | input | 1 | Advances the status stream by one bit |
| booster_run | output | 1 | Booster actually running |
| display_drive | output | 1 | Panel outputs actively driven |
| partial_drive | output | 1 | Partial-area drive in effect |
| all_on_drive | output | 1 | All pixels forced on |
| all_off_drive | output | 1 | All pixels forced off |
| invert_drive | output | 1 | Pixel inversion in effect |
| idle_drive | output | 1 | Reduced-colour drive in effect |
| tear_en | output | 1 | Tearing output enabled |
| stat_busy | output | 1 | Status stream in progress |
| stat_sdo | output | 1 | Serial status bit |
| cmd_err | output | 1 | One-cycle pulse for a forbidden opcode |

## Verification
The bench builds the block with its defaults: two synchronizer stages and the fixed 32-bit status word. With these values the ready-to-drive delay is two edges and a whole read takes 33 strobes. Both are short enough to run many times inside a long random command stream. The random stream mixes every listed opcode with forbidden and undefined bytes. It also moves the supply-ready level and the configuration inputs, so that sleep masking, mutual cancellation, read aborts and commands landing on a shift strobe all occur many times against the reference model.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
// Shared opcodes, action codes and the stored mode record for the
// display mode controller. Assumes one-byte opcodes.
package dmc_pkg;

    localparam int CMD_W  = 8;
    localparam int STAT_W = 32;

    localparam logic [CMD_W-1:0] OP_SWRST     = 8'h01;
    localparam logic [CMD_W-1:0] OP_BOOST_OFF = 8'h02;
    localparam logic [CMD_W-1:0] OP_BOOST_ON  = 8'h03;
    localparam logic [CMD_W-1:0] OP_STATUS    = 8'h09;
    localparam logic [CMD_W-1:0] OP_SLEEP_IN  = 8'h10;
    localparam logic [CMD_W-1:0] OP_SLEEP_OUT = 8'h11;
    localparam logic [CMD_W-1:0] OP_PARTIAL   = 8'h12;
    localparam logic [CMD_W-1:0] OP_NORMAL    = 8'h13;
    localparam logic [CMD_W-1:0] OP_INV_OFF   = 8'h20;
    localparam logic [CMD_W-1:0] OP_INV_ON    = 8'h21;
    localparam logic [CMD_W-1:0] OP_ALL_OFF   = 8'h22;
    localparam logic [CMD_W-1:0] OP_ALL_ON    = 8'h23;
    localparam logic [CMD_W-1:0] OP_DISP_OFF  = 8'h28;
    localparam logic [CMD_W-1:0] OP_DISP_ON   = 8'h29;
    localparam logic [CMD_W-1:0] OP_TEAR_OFF  = 8'h34;
    localparam logic [CMD_W-1:0] OP_TEAR_ON   = 8'h35;
    localparam logic [CMD_W-1:0] OP_IDLE_OFF  = 8'h38;
    localparam logic [CMD_W-1:0] OP_IDLE_ON   = 8'h39;

    // Forbidden opcode ranges
    localparam logic [CMD_W-1:0] BAD_LO_A = 8'hB0;
    localparam logic [CMD_W-1:0] BAD_HI_A = 8'hB9;
    localparam logic [CMD_W-1:0] BAD_LO_B = 8'hDE;

    typedef enum logic [4:0] {
        ACT_NONE, ACT_SWRST, ACT_BOOST_OFF, ACT_BOOST_ON, ACT_STATUS,
        ACT_SLEEP_IN, ACT_SLEEP_OUT, ACT_PARTIAL, ACT_NORMAL,
        ACT_INV_OFF, ACT_INV_ON, ACT_ALL_OFF, ACT_ALL_ON,
        ACT_DISP_OFF, ACT_DISP_ON, ACT_TEAR_OFF, ACT_TEAR_ON,
        ACT_IDLE_OFF, ACT_IDLE_ON
    } dmc_act_e;

    typedef struct packed {
        logic awake;
        logic boost;
        logic disp;
        logic inv;
        logic normal;
        logic partial;
        logic all_on;
        logic all_off;
        logic idle;
        logic tear;
    } dmc_mode_t;

    localparam dmc_mode_t MODE_RESET = '{
        awake: 1'b0, boost: 1'b1, disp: 1'b1, inv: 1'b0, normal: 1'b1,
        partial: 1'b0, all_on: 1'b0, all_off: 1'b0, idle: 1'b0, tear: 1'b0
    };

endpackage

// File: rtl/dmc_cmd_decode.sv
`timescale 1ns/1ps
// Opcode classifier: maps a command byte to an action and flags the
// forbidden ranges. Purely combinational; assumes cmd_byte is stable
// while cmd_valid is high.
module dmc_cmd_decode
    import dmc_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_byte,
    output dmc_act_e         act,
    output logic             forbidden
);

    // Range test for opcodes that must be rejected
    always_comb begin
        forbidden = ((cmd_byte >= BAD_LO_A) && (cmd_byte <= BAD_HI_A)) ||
                    (cmd_byte >= BAD_LO_B);
    end

    // Exact-match lookup of the supported single-byte commands
    always_comb begin
        unique case (cmd_byte)
            OP_SWRST:     act = ACT_SWRST;
            OP_BOOST_OFF: act = ACT_BOOST_OFF;
            OP_BOOST_ON:  act = ACT_BOOST_ON;
            OP_STATUS:    act = ACT_STATUS;
            OP_SLEEP_IN:  act = ACT_SLEEP_IN;
            OP_SLEEP_OUT: act = ACT_SLEEP_OUT;
            OP_PARTIAL:   act = ACT_PARTIAL;
            OP_NORMAL:    act = ACT_NORMAL;
            OP_INV_OFF:   act = ACT_INV_OFF;
            OP_INV_ON:    act = ACT_INV_ON;
            OP_ALL_OFF:   act = ACT_ALL_OFF;
            OP_ALL_ON:    act = ACT_ALL_ON;
            OP_DISP_OFF:  act = ACT_DISP_OFF;
            OP_DISP_ON:   act = ACT_DISP_ON;
            OP_TEAR_OFF:  act = ACT_TEAR_OFF;
            OP_TEAR_ON:   act = ACT_TEAR_ON;
            OP_IDLE_OFF:  act = ACT_IDLE_OFF;
            OP_IDLE_ON:   act = ACT_IDLE_ON;
            default:      act = ACT_NONE;
        endcase
    end

endmodule

// File: rtl/dmc_sync.sv
`timescale 1ns/1ps
// Level synchronizer for the supply-ready signal. STAGES flops in series,
// cleared by reset. Assumes the input is a slow level, not a pulse.
module dmc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous level
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                // Later stages pass the value along
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dmc_stat_ser.sv
`timescale 1ns/1ps
// Status serializer: captures a word with one leading dummy bit and
// shifts it out MSB first on each shift strobe. Any other command
// (abort) ends the stream; load has priority over abort and shift.
module dmc_stat_ser #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              abort,
    input  logic              shift,
    input  logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              sdo
);

    localparam int LEN   = WORD_W + 1;
    localparam int CNT_W = $clog2(LEN + 1);

    logic [LEN-1:0]   sreg_q;
    logic [CNT_W-1:0] cnt_q;

    // Shift register and remaining-bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            sreg_q <= {1'b0, word};
            cnt_q  <= CNT_W'(LEN);
        end else if (abort) begin
            cnt_q  <= '0;
        end else if (shift && (cnt_q != '0)) begin
            sreg_q <= {sreg_q[LEN-2:0], 1'b0};
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign sdo  = busy & sreg_q[LEN-1];

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LEN));

    // R12
    abort_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !load) |=> !busy);

endmodule

// File: rtl/dmc_mode_ctrl.sv
`timescale 1ns/1ps
// Display mode and power state controller. Decodes one-byte commands,
// holds the stored mode flags, derives effective drive enables gated by
// sleep and synchronized supply readiness, and streams a status word.
// Assumes cmd_valid is a one-cycle strobe per command.
module dmc_mode_ctrl
    import dmc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             supply_rdy_async,
    input  logic [4:0]       orient_cfg,
    input  logic [2:0]       pixfmt_cfg,
    input  logic             stat_shift,
    output logic             booster_run,
    output logic             display_drive,
    output logic             partial_drive,
    output logic             all_on_drive,
    output logic             all_off_drive,
    output logic             invert_drive,
    output logic             idle_drive,
    output logic             tear_en,
    output logic             stat_busy,
    output logic             stat_sdo,
    output logic             cmd_err
);

    dmc_act_e          act;
    logic              forbidden;
    logic              rdy_sync;
    dmc_mode_t         mode_q;
    dmc_mode_t         mode_d;
    logic              err_q;
    logic              supply_ok;
    logic [STAT_W-1:0] stat_word;
    logic              accept;

    dmc_cmd_decode u_dec (
        .cmd_byte  (cmd_byte),
        .act       (act),
        .forbidden (forbidden)
    );

    dmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (supply_rdy_async),
        .q_sync  (rdy_sync)
    );

    assign accept = cmd_valid && !forbidden;

    // Next-state rules for the stored flags, including mutual exits
    always_comb begin
        mode_d = mode_q;
        if (accept) begin
            case (act)
                ACT_SWRST:     mode_d = MODE_RESET;
                ACT_BOOST_OFF: mode_d.boost = 1'b0;
                ACT_BOOST_ON:  mode_d.boost = 1'b1;
                ACT_SLEEP_IN:  mode_d.awake = 1'b0;
                ACT_SLEEP_OUT: mode_d.awake = 1'b1;
                ACT_PARTIAL: begin
                    mode_d.partial = 1'b1;
                    mode_d.normal  = 1'b0;
                    mode_d.all_on  = 1'b0;
                    mode_d.all_off = 1'b0;
                end
                ACT_NORMAL: begin
                    mode_d.normal  = 1'b1;
                    mode_d.partial = 1'b0;
                    mode_d.all_on  = 1'b0;
                    mode_d.all_off = 1'b0;
                end
                ACT_INV_OFF:   mode_d.inv = 1'b0;
                ACT_INV_ON:    mode_d.inv = 1'b1;
                ACT_ALL_OFF: begin
                    mode_d.all_off = 1'b1;
                    mode_d.all_on  = 1'b0;
                end
                ACT_ALL_ON: begin
                    mode_d.all_on  = 1'b1;
                    mode_d.all_off = 1'b0;
                end
                ACT_DISP_OFF:  mode_d.disp = 1'b0;
                ACT_DISP_ON:   mode_d.disp = 1'b1;
                ACT_TEAR_OFF:  mode_d.tear = 1'b0;
                ACT_TEAR_ON:   mode_d.tear = 1'b1;
                ACT_IDLE_OFF:  mode_d.idle = 1'b0;
                ACT_IDLE_ON:   mode_d.idle = 1'b1;
                default:       mode_d = mode_q;
            endcase
        end
    end

    // Stored mode flags
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RESET;
        else        mode_q <= mode_d;
    end

    // One-cycle error pulse for rejected opcodes
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= cmd_valid && forbidden;
    end

    // Effective enables derived from stored flags and readiness
    always_comb begin
        supply_ok     = mode_q.boost & rdy_sync;
        booster_run   = mode_q.boost & mode_q.awake;
        display_drive = mode_q.awake & mode_q.disp & supply_ok;
        partial_drive = display_drive & mode_q.partial;
        all_on_drive  = display_drive & mode_q.all_on;
        all_off_drive = display_drive & mode_q.all_off;
        invert_drive  = display_drive & mode_q.inv & ~mode_q.all_on & ~mode_q.all_off;
        idle_drive    = display_drive & mode_q.idle;
        tear_en       = mode_q.tear;
        cmd_err       = err_q;
    end

    // Status word assembly
    always_comb begin
        stat_word = {supply_ok, orient_cfg, 3'b000, pixfmt_cfg,
                     mode_q.idle, mode_q.partial, mode_q.awake, mode_q.normal,
                     1'b0, 1'b0, mode_q.inv, mode_q.all_on, mode_q.all_off,
                     mode_q.disp, mode_q.tear, 9'b0};
    end

    dmc_stat_ser #(.WORD_W(STAT_W)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd_valid && !forbidden && (act == ACT_STATUS)),
        .abort (cmd_valid),
        .shift (stat_shift),
        .word  (stat_word),
        .busy  (stat_busy),
        .sdo   (stat_sdo)
    );

    // R2
    sleep_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte == OP_SLEEP_IN) |=>
            (mode_q.boost == $past(mode_q.boost)) && (mode_q.disp == $past(mode_q.disp)));

    // R4
    drive_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        display_drive |-> rdy_sync);

    // R5
    partial_normal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({mode_q.partial, mode_q.normal}));

    // R6
    all_on_off_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_q.all_on && mode_q.all_off));

    // R9
    err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $stable(mode_q));

endmodule

// File: tb/dmc_mode_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on every edge and compared
// to every output after each edge.
module dmc_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       supply_rdy_async = 1'b0;
    logic [4:0] orient_cfg = 5'h00;
    logic [2:0] pixfmt_cfg = 3'h3;
    logic       stat_shift = 1'b0;
    logic booster_run, display_drive, partial_drive, all_on_drive, all_off_drive;
    logic invert_drive, idle_drive, tear_en, stat_busy, stat_sdo, cmd_err;

    int checks = 0;
    int errors = 0;
    string ph = "R1 reset";

    always #5 clk = ~clk;

    dmc_mode_ctrl u_dmc_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .supply_rdy_async(supply_rdy_async), .orient_cfg(orient_cfg),
        .pixfmt_cfg(pixfmt_cfg), .stat_shift(stat_shift),
        .booster_run(booster_run), .display_drive(display_drive),
        .partial_drive(partial_drive), .all_on_drive(all_on_drive),
        .all_off_drive(all_off_drive), .invert_drive(invert_drive),
        .idle_drive(idle_drive), .tear_en(tear_en), .stat_busy(stat_busy),
        .stat_sdo(stat_sdo), .cmd_err(cmd_err)
    );

    // Reference model state
    bit m_awake, m_boost, m_disp, m_inv, m_norm, m_part, m_on, m_off, m_idle, m_tear;
    bit m_s1, m_s2, m_err;
    bit [32:0] m_bits;
    int m_cnt;

    task automatic model_defaults();
        m_awake = 0; m_boost = 1; m_disp = 1; m_inv = 0; m_norm = 1;
        m_part = 0; m_on = 0; m_off = 0; m_idle = 0; m_tear = 0;
    endtask

    function automatic bit [31:0] model_word();
        bit [31:0] w = '0;
        w[31] = m_boost & m_s2;
        w[30:26] = orient_cfg;
        w[22:20] = pixfmt_cfg;
        w[19] = m_idle; w[18] = m_part; w[17] = m_awake; w[16] = m_norm;
        w[13] = m_inv; w[12] = m_on; w[11] = m_off; w[10] = m_disp; w[9] = m_tear;
        return w;
    endfunction

    task automatic model_edge();
        bit bad;
        if (!rst_n) begin
            model_defaults();
            m_s1 = 0; m_s2 = 0; m_err = 0; m_cnt = 0; m_bits = '0;
            return;
        end
        bad = (cmd_byte >= 8'hB0 && cmd_byte <= 8'hB9) || cmd_byte >= 8'hDE;
        m_err = cmd_valid && bad;
        if (cmd_valid) begin
            if (!bad && cmd_byte == 8'h09) begin
                m_bits = {1'b0, model_word()};
                m_cnt = 33;
            end else m_cnt = 0;
        end else if (stat_shift && m_cnt > 0) begin
            m_bits = m_bits << 1;
            m_cnt--;
        end
        if (cmd_valid && !bad) begin
            case (cmd_byte)
                8'h01: model_defaults();
                8'h02: m_boost = 0;
                8'h03: m_boost = 1;
                8'h10: m_awake = 0;
                8'h11: m_awake = 1;
                8'h12: begin m_part = 1; m_norm = 0; m_on = 0; m_off = 0; end
                8'h13: begin m_norm = 1; m_part = 0; m_on = 0; m_off = 0; end
                8'h20: m_inv = 0;
                8'h21: m_inv = 1;
                8'h22: begin m_off = 1; m_on = 0; end
                8'h23: begin m_on = 1; m_off = 0; end
                8'h28: m_disp = 0;
                8'h29: m_disp = 1;
                8'h34: m_tear = 0;
                8'h35: m_tear = 1;
                8'h38: m_idle = 0;
                8'h39: m_idle = 1;
                default: ;
            endcase
        end
        m_s2 = m_s1;
        m_s1 = supply_rdy_async;
    endtask

    task automatic chk(input logic act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", ph, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit drv = m_awake & m_disp & m_boost & m_s2;
        chk(booster_run, m_boost & m_awake, "R2 booster_run");
        chk(display_drive, drv, "R4 display_drive");
        chk(partial_drive, drv & m_part, "R5 partial_drive");
        chk(all_on_drive, drv & m_on, "R6 all_on_drive");
        chk(all_off_drive, drv & m_off, "R6 all_off_drive");
        chk(invert_drive, drv & m_inv & !m_on & !m_off, "R6 invert_drive");
        chk(idle_drive, drv & m_idle, "R7 idle_drive");
        chk(tear_en, m_tear, "R7 tear_en");
        chk(stat_busy, m_cnt != 0, "R11 stat_busy");
        chk(stat_sdo, (m_cnt != 0) & m_bits[32], "R10 R11 stat_sdo");
        chk(cmd_err, m_err, "R9 cmd_err");
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic send(input logic [7:0] c);
        cmd_valid = 1'b1; cmd_byte = c;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic read_all();
        send(8'h09);
        stat_shift = 1'b1;
        for (int i = 0; i < 34; i++) tick();
        stat_shift = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(1_500_000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pool [20] = '{8'h01, 8'h02, 8'h03, 8'h09, 8'h10, 8'h11,
            8'h12, 8'h13, 8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h29, 8'h34,
            8'h35, 8'h38, 8'h39, 8'hB4, 8'hDD};
        // R1 reset state
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        tick();
        // R2 R4 wake with supply low, then raise ready: two-edge delay
        ph = "R2 R4 wake";
        send(8'h11);
        supply_rdy_async = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        // R10 R11 full status read
        ph = "R10 R11 read";
        orient_cfg = 5'h15; pixfmt_cfg = 3'h5;
        read_all();
        // R3 R2 booster/display flags kept across sleep
        ph = "R3 R2 sleep mask";
        send(8'h28); send(8'h10); send(8'h29); send(8'h11); send(8'h02); send(8'h03);
        // R5 R6 R7 mode exits and inversion override
        ph = "R5 R6 R7 modes";
        send(8'h21); send(8'h23); send(8'h22); send(8'h12); send(8'h23);
        send(8'h13); send(8'h39); send(8'h35); send(8'h38);
        // R9 forbidden and undefined opcodes
        ph = "R9 bad opcodes";
        send(8'hB0); send(8'hB9); send(8'hDE); send(8'hFF); send(8'hDD); send(8'h00); send(8'hBA);
        // R12 abort and restart of a read
        ph = "R12 abort";
        send(8'h09); stat_shift = 1'b1; tick(); tick();
        cmd_valid = 1'b1; cmd_byte = 8'h00; tick(); cmd_valid = 1'b0;
        tick();
        send(8'h09); tick(); send(8'h09); tick(); stat_shift = 1'b0;
        // R8 software reset during a read
        ph = "R8 soft reset";
        send(8'h21); send(8'h09); stat_shift = 1'b1; tick(); stat_shift = 1'b0;
        send(8'h01); tick();
        // Random mix
        ph = "random R2 R5 R6 R9 R11 R12";
        for (int i = 0; i < 6000; i++) begin
            stat_shift = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 19) == 0) supply_rdy_async = ~supply_rdy_async;
            if ($urandom_range(0, 49) == 0) begin
                orient_cfg = 5'($urandom); pixfmt_cfg = 3'($urandom);
            end
            if ($urandom_range(0, 9) < 2) begin
                cmd_valid = 1'b1;
                cmd_byte = ($urandom_range(0, 4) == 0) ? 8'($urandom)
                                                       : pool[$urandom_range(0, 19)];
            end else cmd_valid = 1'b0;
            tick();
        end
        cmd_valid = 1'b0; stat_shift = 1'b0;
        ph = "R10 final read";
        send(8'h11); read_all();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule